// File: doc/BRIEF.md
# Four-Bank Low-Order Interleaved Memory Controller

This controller sits between a single requester and four independent memory banks. It takes one read or write request per bus cycle on a valid/ready port. The two lowest address bits select the bank, and the upper bits become the word address inside that bank. Each bank stays occupied for a full memory cycle of `MEM_CYC` bus cycles. Requests that walk through consecutive addresses therefore spread across the banks and overlap in time. A request aimed at a bank that is still occupied is held off by dropping ready.

Read data comes back from the banks on separate per-bank return lines. A bank with a shorter latency may answer before an older read sent to a slower bank. A small tag queue records the bank of every outstanding read. A two-entry holding buffer per bank parks early data until its turn, so responses always leave in the order the reads were accepted. Writes produce no response beat, but they occupy their bank for the same memory cycle. A bank must answer a read within `MEM_CYC-1` cycles of its strobe.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: An accepted request raises exactly one strobe in `bank_req`, in the same cycle. The strobed bank is `req_addr[1:0]`. `bank_addr` carries `req_addr[ADDR_W-1:2]`, and `bank_we`/`bank_wdata` copy the request.
- R2: When the target bank is idle, a write is accepted at once. A sequential address stream with one request per cycle is accepted without any stall.
- R3: A bank accepted on clock edge n receives no other access before edge n+MEM_CYC. A request held to that bank is accepted exactly on edge n+MEM_CYC, provided no read-return limit blocks it.
- R4: A write produces no response beat. It still occupies its bank for MEM_CYC cycles. `rsp_valid` never rises without an outstanding read.
- R5: Read responses leave in acceptance order, including when banks finish out of order. Each response carries the most recently written data for its address, or zero if the address was never written.
- R6: While one bank is occupied, requests to the other banks are accepted without waiting.
- R7: After reset, `rsp_valid` is low, no bank strobe is raised, and an idle bank accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Word address; low 2 bits pick the bank |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | DATA_W | Read response data |
| bank_req | output | 4 | One-hot bank access strobe |
| bank_we | output | 1 | Write flag shared by the banks |
| bank_addr | output | ADDR_W-2 | Word address inside the bank |
| bank_wdata | output | DATA_W | Write data shared by the banks |
| bank_rvalid | input | 4 | Per-bank read data valid |
| bank_rdata | input | 4*DATA_W | Per-bank read data, bank b at bits [b*DATA_W +: DATA_W] |

## Verification
A busy counter that is off by one cycle appears at once as a wrong number of ready-low cycles on the very next request to that bank. Measuring the wait of every request against the last acceptance time of its bank therefore exposes such a fault within one memory cycle. A corrupted tag queue or holding buffer shows up at the response port as swapped or stale data. Once the fast and slow banks are mixed, this appears within a few beats. A lost entry shows up as responses left missing when the stream drains.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // bank number: low-order address bits
  function automatic logic [31:0] bank_of(input logic [31:0] addr, input int sel_w);
    return addr & ((32'd1 << sel_w) - 32'd1);
  endfunction
  // word position inside the bank: remaining upper bits
  function automatic logic [31:0] word_of(input logic [31:0] addr, input int sel_w);
    return addr >> sel_w;
  endfunction
endpackage

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYC - 1);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ilv_ret_hold.sv
module ilv_ret_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic          vld,
  output logic          full,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] e0, e1;
  logic [1:0]    cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 2'd0;
      e0  <= '0;
      e1  <= '0;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) e0 <= din;
          else             e1 <= din;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          e0  <= e1;
          cnt <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) e0 <= din;
          else begin
            e0 <= e1;
            e1 <= din;
          end
        end
        default: ;
      endcase
    end
  end

  assign vld  = (cnt != 2'd0);
  assign full = (cnt == 2'd2);
  assign dout = e0;
endmodule

// File: rtl/ilv_tag_fifo.sv
module ilv_tag_fifo #(
  parameter int TW    = 2,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] din,
  input  logic          pop,
  output logic [TW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);
  logic [TW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + (PW+1)'(1);
      else if (pop && !push) cnt <= cnt - (PW+1)'(1);
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 2,
  parameter int MEM_CYC = 4,
  parameter int QDEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         req_we,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_data,
  output logic [(1<<SEL_W)-1:0]        bank_req,
  output logic                         bank_we,
  output logic [ADDR_W-SEL_W-1:0]      bank_addr,
  output logic [DATA_W-1:0]            bank_wdata,
  input  logic [(1<<SEL_W)-1:0]        bank_rvalid,
  input  logic [(1<<SEL_W)*DATA_W-1:0] bank_rdata
);
  import ilv_pkg::*;
  localparam int NB   = 1 << SEL_W;
  localparam int BA_W = ADDR_W - SEL_W;

  logic [31:0]          sel32, word32;
  logic [SEL_W-1:0]     sel;
  logic [NB-1:0]        busy, hold_vld, hold_full, hold_pop;
  logic [NB*DATA_W-1:0] hold_data;
  logic [SEL_W-1:0]     q_head;
  logic                 q_empty, q_full;
  // named internal events, also watched by the checker
  logic                 accept, rd_push, pop, sel_free, sel_room;

  always_comb begin
    sel32  = bank_of(32'(req_addr), SEL_W);
    word32 = word_of(32'(req_addr), SEL_W);
    sel    = sel32[SEL_W-1:0];
  end

  // a read may also enter when the selected hold drains this very cycle
  assign sel_free  = !busy[sel];
  assign sel_room  = !hold_full[sel] || hold_pop[sel];
  assign req_ready = sel_free && (req_we || (sel_room && !q_full));
  assign accept    = req_valid && req_ready;
  assign rd_push   = accept && !req_we;

  assign bank_we    = req_we;
  assign bank_addr  = word32[BA_W-1:0];
  assign bank_wdata = req_wdata;

  assign rsp_valid = !q_empty && hold_vld[q_head];
  assign rsp_data  = hold_data[q_head*DATA_W +: DATA_W];
  assign pop       = rsp_valid;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_req[b] = accept && (sel == SEL_W'(b));
    assign hold_pop[b] = pop && (q_head == SEL_W'(b));

    ilv_bank_timer #(.CYC(MEM_CYC)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (bank_req[b]),
      .busy  (busy[b])
    );

    ilv_ret_hold #(.DW(DATA_W)) hold_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (bank_rvalid[b]),
      .din   (bank_rdata[b*DATA_W +: DATA_W]),
      .pop   (hold_pop[b]),
      .vld   (hold_vld[b]),
      .full  (hold_full[b]),
      .dout  (hold_data[b*DATA_W +: DATA_W])
    );
  end

  ilv_tag_fifo #(.TW(SEL_W), .DEPTH(QDEPTH)) tagq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rd_push),
    .din   (sel),
    .pop   (pop),
    .head  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
  parameter int ADDR_W  = 8,
  parameter int SEL_W   = 2,
  parameter int MEM_CYC = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    req_we,
  input logic                    rsp_valid,
  input logic [(1<<SEL_W)-1:0]   bank_req,
  input logic [ADDR_W-SEL_W-1:0] bank_addr,
  input logic                    accept
);
  localparam int NB = 1 << SEL_W;
  int gap [NB];
  int outstanding;
  logic [SEL_W-1:0] tgt;
  assign tgt = req_addr[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= 0;
      for (int b = 0; b < NB; b++) gap[b] <= MEM_CYC;
    end else begin
      outstanding <= outstanding + ((accept && !req_we) ? 1 : 0) - (rsp_valid ? 1 : 0);
      for (int b = 0; b < NB; b++) begin
        if (bank_req[b])          gap[b] <= 1;
        else if (gap[b] < MEM_CYC) gap[b] <= gap[b] + 1;
      end
    end
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req));

  // R1
  strobe_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (bank_req[tgt] && bank_addr == req_addr[ADDR_W-1:SEL_W]));

  // R2
  idle_write_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && gap[tgt] >= MEM_CYC) |-> req_ready);

  // R4
  no_orphan_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (outstanding != 0));

  for (genvar b = 0; b < NB; b++) begin : g_gap
    // R3
    bank_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_req[b] |-> (gap[b] >= MEM_CYC));
  end
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .SEL_W  (SEL_W),
  .MEM_CYC(MEM_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_we    (req_we),
  .rsp_valid (rsp_valid),
  .bank_req  (bank_req),
  .bank_addr (bank_addr),
  .accept    (accept)
);

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;
  localparam int AW = 8, DW = 16, SW = 2, MC = 4, NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, bank_we;
  logic [DW-1:0] rsp_data, bank_wdata;
  logic [NB-1:0] bank_req;
  logic [AW-SW-1:0] bank_addr;
  logic [NB-1:0] bank_rvalid;
  logic [NB*DW-1:0] bank_rdata;

  always #4 clk = ~clk;  // 125 MHz

  ilv_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SEL_W(SW), .MEM_CYC(MC), .QDEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bank_req(bank_req), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_rvalid(bank_rvalid),
    .bank_rdata(bank_rdata));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int last_acc [NB];
  logic [DW-1:0] ref_mem [256];
  logic [DW-1:0] expq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bank models: latency 1,2,3,1 so completions can reorder
  logic [DW-1:0] bmem [NB][64];
  int bcnt [NB];
  logic [AW-SW-1:0] padr [NB];
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n) begin
        bcnt[b] <= 0;
        bank_rvalid[b] <= 1'b0;
      end else begin
        bank_rvalid[b] <= (bcnt[b] == 1);
        if (bcnt[b] == 1) bank_rdata[b*DW +: DW] <= bmem[b][padr[b]];
        if (bcnt[b] != 0) bcnt[b] <= bcnt[b] - 1;
        if (bank_req[b]) begin
          if (bank_we) bmem[b][bank_addr] <= bank_wdata;
          else begin
            bcnt[b] <= (b % 3) + 1;
            padr[b] <= bank_addr;
          end
        end
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R4 response without read", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        chk(rsp_data == e, "R5 response data/order", int'(rsp_data), int'(e));
      end
    end
  end

  // mode: 0 = exact wait, 1 = wait at least busy bound
  task automatic send(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                      input int mode, input string tag);
    int waits, b, expw;
    b = int'(a[1:0]);
    waits = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
    expw = last_acc[b] + MC - (cyc + 1);
    if (expw < 0) expw = 0;
    #1;
    while (!req_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    if (mode == 0) chk(waits == expw, tag, waits, expw);
    else           chk(waits >= expw, "R3 no early access", waits, expw);
    chk(bank_req == (4'b1 << b) && bank_addr == a[AW-1:SW] && bank_we == w &&
        (!w || bank_wdata == d), "R1 routing", int'(bank_req), 1 << b);
    last_acc[b] = cyc + 1;
    if (w) ref_mem[a] = d;
    else   expq.push_back(ref_mem[a]);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && expq.size() != 0; i++) @(negedge clk);
    repeat (MC) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    for (int b = 0; b < NB; b++) begin
      last_acc[b] = -100;
      for (int j = 0; j < 64; j++) bmem[b][j] = '0;
    end
    bank_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(rsp_valid == 1'b0, "R7 rsp_valid after reset", int'(rsp_valid), 0);
    chk(bank_req == '0, "R7 no strobe after reset", int'(bank_req), 0);
    req_addr = 8'd5; req_we = 1'b0;
    #1 chk(req_ready == 1'b1, "R7 idle bank ready", int'(req_ready), 1);

    // never-written read returns zero (R5)
    send(8'd7, 1'b0, '0, 0, "R2 first read");
    drain();

    // R2/R4: sequential writes, one per cycle, no responses
    for (int a = 0; a < 64; a++) send(8'(a), 1'b1, 16'(16'hA000 ^ (a * 37)), 0, "R2 sequential write");
    // R2/R5: sequential reads, no stalls, ordered data despite mixed latency
    for (int a = 0; a < 64; a++) send(8'(a), 1'b0, '0, 0, "R2 sequential read");
    drain();

    // R3/R4: same-bank stream, alternate write/read, spacing MEM_CYC
    for (int i = 0; i < 16; i++) send(8'(4 * i + 1), (i % 2) == 0, 16'(16'h5000 + i), 0, "R3 same bank spacing");
    drain();

    // R6: other banks enter while bank 0 is busy after a write (R4)
    for (int k = 0; k < 8; k++) begin
      send(8'(16 * k),     1'b1, 16'(16'h7700 + k), 0, "R4 write occupies bank");
      send(8'(16 * k + 1), 1'b0, '0, 0, "R6 overlap other bank");
      send(8'(16 * k + 2), 1'b1, 16'(k), 0, "R6 overlap other bank");
      send(8'(16 * k + 4), 1'b0, '0, 0, "R3 held then accepted");
    end
    drain();

    // near-exhaustive stride sweep with mixed directions
    for (int s = 1; s < 8; s++)
      for (int n = 0; n < 24; n++)
        send(8'(3 * s + n * s), ((n + s) % 3) == 0, 16'(s * 1000 + n), 1, "sweep");
    drain();
    chk(expq.size() == 0, "R5 all reads answered", expq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule